// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 32 interrupt sources and drives two active-low request lines toward a processor: a normal request and a fast request. Each source has its own enable bit, a 3-bit priority level, a trigger mode and a 32-bit handler vector. Among the enabled pending sources routed to the normal line, the controller selects the one with the highest level and presents its vector on a register read. Source 0 is the dedicated fast source. Any other source can be force-routed to the fast line, which removes it from normal arbitration.

Reading the vector register acknowledges the selected source. The read clears the source's edge-latched pending bit and pushes its level onto an internal stack. From then on, only a source of strictly higher level asserts the normal line again, which allows nesting. A write to the end-of-service register pops the stack. In protect mode the vector read has no side effects, and a write to the vector address performs the acknowledge instead. This lets a debugger inspect the vector without disturbing the controller.

The register bus is a single-cycle access. Read data is combinational on the addressed register, and any side effect takes place at the clock edge that ends the access. Byte offsets are as follows:
- Control: 0x000. Bit 0 selects protect mode.
- Enable mask: 0x004.
- Fast-force mask: 0x008.
- Spurious vector: 0x00C.
- Vector: 0x010.
- End of service: 0x014.
- Pending view: 0x018, read only.
- Fast edge clear: 0x01C, write only.
- Per-source configuration: 0x100 + 4·n.
- Per-source vector: 0x200 + 4·n.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset both request lines are high, all sources are masked, none is forced, the stack is empty and the pending view (offset 0x018) reads 0.
- R2: Configuration bits [4:3] select the trigger mode: 00 high level, 01 low level, 10 rising edge, 11 falling edge. A level source is pending while its input is at the active level, and an edge source is pending from the edge until it is cleared. A source whose enable bit is 0 asserts neither line.
- R3: An edge-mode source latches its pending bit on the selected edge, and the bit stays set after the input returns.
- R4: Configuration bits [2:0] give the level (7 highest). The normal arbiter covers sources 1 to 31 only, picks the highest level and breaks a tie in favour of the lower source number.
- R5: A read of offset 0x010 returns the selected source's vector while the normal line is asserted. Otherwise it returns the spurious vector and leaves the stack unchanged.
- R6: Outside protect mode, a vector read that returns a source's vector has three effects: it clears that source's edge pending bit, it pushes its level, and it keeps the normal line high until a source of strictly higher level is pending.
- R7: Any write to offset 0x014 with a non-empty stack pops one level, so sources at or below the previous top level can assert the normal line again.
- R8: Source 0, when enabled and pending, drives only the fast line and never the normal line.
- R9: A source whose fast-force bit is set asserts the fast line and takes no part in normal arbitration.
- R10: With protect mode on (control bit 0 = 1), a vector read changes no state. A write to offset 0x010 then performs the acknowledge of R6, and outside protect mode such a write is ignored.
- R11: Writing a mask to offset 0x01C clears the edge pending bits set in the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Raw interrupt source inputs |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational on the address |
| irq_n | output | 1 | Active-low normal request |
| fiq_n | output | 1 | Active-low fast request |

## Verification
The embedded assertions check on every cycle that the stack stays within its depth, and that each acknowledge pushes exactly one level. They also check that each end-of-service with no acknowledge pops exactly one, that protected and spurious reads leave the stack alone, and that a forced source is never the normal request. Only the bench scenarios can show the ordering results. These are which vector wins under mixed levels and ties, nested preemption and its release after a pop, edge latching that outlives the input pulse, and the spurious vector when nothing qualifies.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NSRC = 32,
  parameter int NLVL = 8,
  parameter int DW   = 32,
  parameter int AW   = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            bus_en,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_n,
  output logic            fiq_n
);
  localparam int IW = $clog2(NSRC);
  localparam int LW = $clog2(NLVL);
  localparam int SW = $clog2(NLVL + 1);

  localparam logic [AW-1:0] A_CTRL = AW'(12'h000);
  localparam logic [AW-1:0] A_EN   = AW'(12'h004);
  localparam logic [AW-1:0] A_FRC  = AW'(12'h008);
  localparam logic [AW-1:0] A_SPUR = AW'(12'h00C);
  localparam logic [AW-1:0] A_VEC  = AW'(12'h010);
  localparam logic [AW-1:0] A_EOI  = AW'(12'h014);
  localparam logic [AW-1:0] A_PEND = AW'(12'h018);
  localparam logic [AW-1:0] A_FCLR = AW'(12'h01C);
  localparam logic [NSRC-1:0] FAST0 = NSRC'(1);

  logic            protect;
  logic [NSRC-1:0] en_r, frc_r, edge_p, src_q, active;
  logic [DW-1:0]   spur_r;
  logic [LW-1:0]   prio_r [NSRC];
  logic [1:0]      mode_r [NSRC];
  logic [DW-1:0]   vec_r  [NSRC];
  logic [LW-1:0]   stk    [NLVL];
  logic [SW-1:0]   sp;

  logic [1:0]    page;
  logic [IW-1:0] aidx;
  logic          wr, rd, hit_vec, ack, eoi;
  logic          found, irq_req;
  logic [IW-1:0] best;
  logic [LW-1:0] bprio, top;
  logic [NSRC-1:0] nrm, fst;

  assign page    = bus_addr[AW-1 -: 2];
  assign aidx    = bus_addr[2 +: IW];
  assign wr      = bus_en & bus_we;
  assign rd      = bus_en & ~bus_we;
  assign hit_vec = (bus_addr == A_VEC);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_comb begin
      case (mode_r[i])
        2'b00:   active[i] = src_in[i];
        2'b01:   active[i] = ~src_in[i];
        default: active[i] = edge_p[i];
      endcase
    end
  end

  assign nrm   = active & en_r & ~frc_r & ~FAST0;
  assign fst   = active & en_r & (frc_r | FAST0);
  assign fiq_n = ~|fst;

  always_comb begin
    found = 1'b0;
    best  = '0;
    bprio = '0;
    for (int i = 1; i < NSRC; i++) begin
      if (nrm[i] && (!found || prio_r[i] > bprio)) begin
        found = 1'b1;
        best  = IW'(i);
        bprio = prio_r[i];
      end
    end
  end

  assign top     = (sp == '0) ? '0 : stk[LW'(sp - SW'(1))];
  assign irq_req = found && ((sp == '0) || (bprio > top));
  assign irq_n   = ~irq_req;
  assign ack     = irq_req && hit_vec && ((rd && !protect) || (wr && protect));
  assign eoi     = wr && (bus_addr == A_EOI) && (sp != '0);

  always_comb begin
    bus_rdata = '0;
    case (page)
      2'b01: bus_rdata = DW'({mode_r[aidx], prio_r[aidx]});
      2'b10: bus_rdata = vec_r[aidx];
      2'b00: begin
        case (bus_addr)
          A_CTRL:  bus_rdata = DW'(protect);
          A_EN:    bus_rdata = DW'(en_r);
          A_FRC:   bus_rdata = DW'(frc_r);
          A_SPUR:  bus_rdata = spur_r;
          A_VEC:   bus_rdata = irq_req ? vec_r[best] : spur_r;
          A_PEND:  bus_rdata = DW'(active);
          default: bus_rdata = '0;
        endcase
      end
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      protect <= 1'b0;
      en_r    <= '0;
      frc_r   <= '0;
      spur_r  <= '0;
    end else if (wr && page == 2'b00) begin
      case (bus_addr)
        A_CTRL: protect <= bus_wdata[0];
        A_EN:   en_r    <= bus_wdata[NSRC-1:0];
        A_FRC:  frc_r   <= bus_wdata[NSRC-1:0];
        A_SPUR: spur_r  <= bus_wdata;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_r[i] <= '0;
        mode_r[i] <= '0;
        vec_r[i]  <= '0;
      end else if (wr && aidx == IW'(i)) begin
        if (page == 2'b01) begin
          prio_r[i] <= bus_wdata[LW-1:0];
          mode_r[i] <= bus_wdata[LW+1:LW];
        end
        if (page == 2'b10) vec_r[i] <= bus_wdata;
      end
    end

    logic hit_edge, clr;
    assign hit_edge = mode_r[i][1] & (mode_r[i][0] ? (src_q[i] & ~src_in[i])
                                                   : (~src_q[i] & src_in[i]));
    assign clr = (ack && best == IW'(i)) ||
                 (wr && bus_addr == A_FCLR && bus_wdata[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[i]  <= 1'b0;
        edge_p[i] <= 1'b0;
      end else begin
        src_q[i] <= src_in[i];
        if (hit_edge)  edge_p[i] <= 1'b1;
        else if (clr)  edge_p[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
      for (int k = 0; k < NLVL; k++) stk[k] <= '0;
    end else if (ack) begin
      stk[LW'(sp)] <= bprio;
      sp <= sp + SW'(1);
    end else if (eoi) begin
      sp <= sp - SW'(1);
    end
  end

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SW'(NLVL)) else $error("stack depth exceeded"); // R6
  AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> sp == $past(sp) + SW'(1)) else $error("ack did not push"); // R6
  AST_EOI_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack) |=> sp == $past(sp) - SW'(1)) else $error("eoi did not pop"); // R7
  AST_PROTECT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit_vec && protect) |=> $stable(sp)) else $error("protected read changed stack"); // R10
  AST_SPURIOUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && hit_vec && !irq_req) |=> $stable(sp)) else $error("spurious read changed stack"); // R5
  AST_FORCED_NOT_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> !frc_r[best] && best != '0) else $error("forced or fast source on normal line"); // R9
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int N = 32;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_in = '0;
  logic bus_en = 0, bus_we = 0;
  logic [9:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_n, fiq_n;
  int checks = 0, errors = 0;
  bit done = 0;
  int prio_m [N];
  localparam logic [31:0] SPUR = 32'hDEAD_0000;

  irq_vector_ctrl dut (.clk, .rst_n, .src_in, .bus_en, .bus_we, .bus_addr,
                       .bus_wdata, .bus_rdata, .irq_n, .fiq_n);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_en = 0;
  endtask

  task automatic cfg(input int s, input int pr, input int md);
    wr(10'h100 + 10'(4 * s), 32'(md * 8 + pr));
    prio_m[s] = pr;
  endtask

  task automatic do_reset();
    rst_n = 0; src_in = '0; bus_en = 0; #12; rst_n = 1; tick();
    for (int i = 0; i < N; i++) prio_m[i] = 0;
    for (int i = 0; i < N; i++) wr(10'h200 + 10'(4 * i), 32'hA000_0000 + 32'(i));
    wr(10'h00C, SPUR);
  endtask

  function automatic int model_best(input logic [N-1:0] en, input logic [N-1:0] frc,
                                    input logic [N-1:0] src);
    int b = -1;
    for (int i = 1; i < N; i++)
      if (en[i] && !frc[i] && src[i] && (b < 0 || prio_m[i] > prio_m[b])) b = i;
    return b;
  endfunction

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    if (!done) $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [N-1:0] en, frc;
    int b;
    void'($urandom(32'd4242));
    rst_n = 0; #12; rst_n = 1; tick();
    chk("R1 irq_n", 32'(irq_n), 1); chk("R1 fiq_n", 32'(fiq_n), 1);
    rd(10'h004, d); chk("R1 enable", d, 0);
    rd(10'h008, d); chk("R1 force", d, 0);
    src_in = '1; tick();
    rd(10'h018, d); chk("R1 R2 masked pend", d, 32'hFFFF_FFFF);
    chk("R2 masked no irq", 32'(irq_n), 1); chk("R2 masked no fiq", 32'(fiq_n), 1);

    // R2 low level
    do_reset();
    cfg(5, 3, 1); wr(10'h004, 32'h20);
    chk("R2 low level asserts", 32'(irq_n), 0);
    src_in[5] = 1; tick();
    chk("R2 low level released", 32'(irq_n), 1);

    // R3 rising edge latch, R6 ack, R7 eoi
    do_reset();
    cfg(7, 4, 2); wr(10'h004, 32'h80);
    src_in[7] = 1; tick(); src_in[7] = 0; tick();
    chk("R3 rising latched", 32'(irq_n), 0);
    rd(10'h010, d); chk("R5 vector 7", d, 32'hA000_0007);
    chk("R6 irq drops after ack", 32'(irq_n), 1);
    rd(10'h018, d); chk("R6 edge cleared", d[7], 0);
    wr(10'h014, 0);
    // falling edge
    cfg(8, 1, 3); wr(10'h004, 32'h100);
    src_in[8] = 1; tick(); chk("R3 no fall yet", 32'(irq_n), 1);
    src_in[8] = 0; tick(); src_in[8] = 1; tick();
    chk("R3 falling latched", 32'(irq_n), 0);

    // R4 R6 R7 nesting
    do_reset();
    cfg(3, 2, 0); cfg(9, 5, 0); cfg(12, 6, 0);
    wr(10'h004, 32'h1208);
    src_in[3] = 1; src_in[9] = 1; tick();
    rd(10'h010, d); chk("R4 higher level wins", d, 32'hA000_0009);
    chk("R6 lower blocked", 32'(irq_n), 1);
    src_in[12] = 1; tick();
    chk("R6 higher preempts", 32'(irq_n), 0);
    rd(10'h010, d); chk("R6 nested vector", d, 32'hA000_000C);
    chk("R6 blocked at top 6", 32'(irq_n), 1);
    wr(10'h014, 0);
    chk("R7 pop re-enables equal/higher", 32'(irq_n), 0);
    src_in[12] = 0; tick();
    chk("R7 level 2 below top 5", 32'(irq_n), 1);
    wr(10'h014, 0);
    chk("R7 empty stack releases", 32'(irq_n), 0);
    rd(10'h010, d); chk("R4 after pops", d, 32'hA000_0009);
    wr(10'h014, 0);

    // R4 tie
    do_reset();
    cfg(10, 4, 0); cfg(4, 4, 0); wr(10'h004, 32'h410);
    src_in[10] = 1; src_in[4] = 1; tick();
    rd(10'h010, d); chk("R4 tie lower number", d, 32'hA000_0004);

    // R5 spurious
    do_reset();
    rd(10'h010, d); chk("R5 spurious", d, SPUR);
    cfg(2, 0, 0); wr(10'h004, 32'h4); src_in[2] = 1; tick();
    chk("R5 stack unchanged by spurious", 32'(irq_n), 0);

    // R10 protect
    do_reset();
    cfg(6, 3, 2); wr(10'h004, 32'h40);
    src_in[6] = 1; tick(); src_in[6] = 0; tick();
    wr(10'h010, 0);
    chk("R10 write ignored unprotected", 32'(irq_n), 0);
    wr(10'h000, 1);
    rd(10'h010, d); rd(10'h010, d);
    chk("R10 read side-effect free vec", d, 32'hA000_0006);
    chk("R10 read keeps irq", 32'(irq_n), 0);
    wr(10'h010, 0);
    chk("R10 write acknowledges", 32'(irq_n), 1);
    rd(10'h018, d); chk("R10 edge cleared by write ack", d[6], 0);

    // R8 R9 R11 fast
    do_reset();
    wr(10'h004, 32'h41); src_in[0] = 1; tick();
    chk("R8 fast source fiq", 32'(fiq_n), 0); chk("R8 not normal", 32'(irq_n), 1);
    src_in[0] = 0; cfg(6, 7, 2); wr(10'h008, 32'h40);
    src_in[6] = 1; tick(); src_in[6] = 0; tick();
    chk("R9 forced to fiq", 32'(fiq_n), 0); chk("R9 forced off irq", 32'(irq_n), 1);
    rd(10'h010, d); chk("R9 forced not vectored", d, SPUR);
    wr(10'h01C, 32'h40);
    chk("R11 fast clear", 32'(fiq_n), 1);

    // random level-mode scenarios (protect mode reads)
    do_reset();
    wr(10'h000, 1);
    for (int i = 0; i < N; i++) cfg(i, $urandom_range(0, 7), 0);
    for (int it = 0; it < 150; it++) begin
      en = $urandom; frc = $urandom & $urandom;
      wr(10'h004, en); wr(10'h008, frc);
      src_in = $urandom; tick();
      b = model_best(en, frc, src_in);
      chk("R4 random irq", 32'(irq_n), (b < 0) ? 1 : 0);
      chk("R9 random fiq", 32'(fiq_n),
          ((en[0] && src_in[0]) || |(en & frc & src_in)) ? 0 : 1);
      rd(10'h010, d);
      chk("R5 random vector", d, (b < 0) ? SPUR : 32'hA000_0000 + 32'(b));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule